// File: doc/BRIEF.md
# Page-Mode DRAM Burst Read Sequencer

This block drives the strobe, enable and multiplexed address pins of an asynchronous page-mode DRAM. It fetches one cache block as a burst of four column reads inside a single open row. A request supplies a row and a starting column. The sequencer opens the row by driving the row address and pulling the row strobe low. It then steps through four consecutive column addresses, pulsing the column strobe once for each. It captures each data word at the end of its column strobe and presents it on a one-cycle-valid output stream.

Two page modes are selectable per burst with the `edo_mode` input. In plain page mode every later beat pays the full column-strobe high time plus the full column-strobe low time. In extended-data-out mode the device holds the previous word on its outputs while the next column is being presented, so each later column pulse can be one cycle shorter. With the default timing parameters the beats cost 5-3-3-3 cycles (14 per block) in plain mode and 5-2-2-2 cycles (11 per block) in extended mode.

Between bursts the row strobe is held high for a minimum precharge time. A free-running interval timer requests row-only refresh cycles, which walk through the rows one at a time and are only started while no burst is in progress.

Top module: `pgdram_burst_ctrl`

## Requirements
- R1: During and right after reset, `ras_n`, `cas_n`, `oe_n` and `we_n` are high, `rd_valid` is low and `req_ready` is high.
- R2: A burst begins in the cycle after the accepting clock edge (`req_valid` and `req_ready` both high). In that cycle `ras_n` falls and `dram_addr` carries the requested row, zero-extended. `ras_n` then stays low without a break until the burst ends.
- R3: A burst returns exactly four words. Word i is the value of `dram_dq` while `cas_n` is low with column (start + i) modulo 2^COL_W on the low COL_W bits of `dram_addr`. The word is reported on `rd_data` in the cycle after that column strobe ends.
- R4: In plain page mode (`edo_mode` = 0 when accepted), the first `rd_valid` comes RAS_TO_CAS + CAS_LOW cycles after the accepting edge. The following ones come every CAS_HIGH + CAS_LOW cycles, which with the defaults gives 5-3-3-3. `ras_n` stays low for RAS_TO_CAS + CAS_LOW + 3·(CAS_HIGH + CAS_LOW) cycles.
- R5: In extended-data-out mode (`edo_mode` = 1 when accepted), the later beats are spaced CAS_HIGH + CAS_LOW − 1 cycles apart, which with the defaults gives 5-2-2-2. `ras_n` stays low for RAS_TO_CAS + CAS_LOW + 3·(CAS_HIGH + CAS_LOW − 1) cycles.
- R6: `edo_mode` is sampled only at the accepting edge. A change during a burst has no effect on that burst's beat timing.
- R7: After every row-strobe low period, `ras_n` stays high for at least RAS_PRE cycles before it falls again. `req_ready` is low whenever `ras_n` is low.
- R8: Every REF_INTERVAL cycles a refresh is requested. It is served only between bursts, as a row-only cycle: `ras_n` low for RAS_TO_CAS + CAS_LOW cycles while `cas_n` stays high. The refresh rows start at 0 and increase by one per refresh. When the block is idle, refreshes are exactly REF_INTERVAL cycles apart.
- R9: `cas_n` is never low while `ras_n` is high, and `we_n` is always high.
- R10: `rd_valid` is never high in two consecutive cycles, and no `rd_valid` appears outside an accepted burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edo_mode | input | 1 | 1 selects extended-data-out beat timing for the burst being accepted |
| req_valid | input | 1 | Burst request present |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | First column of the four-beat burst |
| req_ready | output | 1 | Block idle with no refresh pending; request accepted on this edge |
| dram_addr | output | ADDR_W | Multiplexed row/column address to the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, low while a read row is open |
| we_n | output | 1 | Write enable, held inactive |
| dram_dq | input | DATA_W | Read data from the DRAM |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | DATA_W | Returned word |

## Verification
The bound checker watches, on every cycle, the properties that hold at any instant. These are: the column strobe only inside a row strobe, the minimum row-strobe high time before each fall, no acceptance while a row is open, `rd_valid` only right after a column strobe, and no two-cycle `rd_valid`. Other properties can only be shown by the bench's scenarios, checked against its cycle-accurate model. These are the exact beat spacing in both modes, the mode being frozen at acceptance, column wrap-around within the row, the values of the returned words, the refresh row sequence, and the exact refresh period in an idle window.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_RD   = 3'd2,
        ST_CPR  = 3'd3,
        ST_PRE  = 3'd4,
        ST_REF  = 3'd5
    } pgd_state_e;

    typedef enum logic {
        AS_ROW = 1'b0,
        AS_COL = 1'b1
    } pgd_asel_e;

endpackage

// File: rtl/pgd_refresh_timer.sv
module pgd_refresh_timer #(
    parameter int INTERVAL = 200,
    parameter int ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } rt_s;

    rt_s q, n;
    logic tick;

    always_comb begin
        n    = q;
        tick = (q.cnt == CNT_W'(INTERVAL - 1));
        if (tick) n.cnt = '0;
        else      n.cnt = q.cnt + 1'b1;
        if (tick)      n.pend = 1'b1;
        else if (take) n.pend = 1'b0;
        if (take) n.row = q.row + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign pending = q.pend;
    assign ref_row = q.row;
endmodule

// File: rtl/pgd_addr_mux.sv
module pgd_addr_mux
    import pgd_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 10
) (
    input  pgd_asel_e         sel,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] row_x, col_x;

    generate
        if (ROW_W == ADDR_W) begin : g_row_full
            assign row_x = row;
        end else begin : g_row_pad
            assign row_x = {{(ADDR_W-ROW_W){1'b0}}, row};
        end
        if (COL_W == ADDR_W) begin : g_col_full
            assign col_x = col;
        end else begin : g_col_pad
            assign col_x = {{(ADDR_W-COL_W){1'b0}}, col};
        end
    endgenerate

    always_comb begin
        addr = (sel == AS_COL) ? col_x : row_x;
    end
endmodule

// File: rtl/pgd_burst_fsm.sv
module pgd_burst_fsm
    import pgd_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 8,
    parameter int DATA_W     = 32,
    parameter int BURST_LEN  = 4,
    parameter int RAS_TO_CAS = 3,
    parameter int CAS_LOW    = 2,
    parameter int CAS_HIGH   = 1,
    parameter int RAS_PRE    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              edo_mode,
    input  logic              ref_pending,
    input  logic [ROW_W-1:0]  ref_row,
    input  logic [DATA_W-1:0] dq,
    output logic              req_ready,
    output logic              ref_take,
    output pgd_asel_e         asel,
    output logic [ROW_W-1:0]  row_out,
    output logic [COL_W-1:0]  col_out,
    output logic              ras_n,
    output logic              cas_n,
    output logic              oe_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W  = $clog2(RAS_TO_CAS + CAS_LOW + CAS_HIGH + RAS_PRE + 1);
    localparam int BEAT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0]  ACT_END  = CNT_W'(RAS_TO_CAS - 1);
    localparam logic [CNT_W-1:0]  RD_FULL  = CNT_W'(CAS_LOW - 1);
    localparam logic [CNT_W-1:0]  RD_SHORT = CNT_W'(CAS_LOW - 2);
    localparam logic [CNT_W-1:0]  CPR_END  = CNT_W'(CAS_HIGH - 1);
    localparam logic [CNT_W-1:0]  PRE_END  = CNT_W'(RAS_PRE - 1);
    localparam logic [CNT_W-1:0]  REF_END  = CNT_W'(RAS_TO_CAS + CAS_LOW - 1);

    typedef struct packed {
        pgd_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BEAT_W-1:0] beat;
        logic              edo;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              rdv;
        logic [DATA_W-1:0] rdata;
    } fsm_s;

    fsm_s q, n;
    logic cnt_done;

    always_comb begin
        n         = q;
        n.rdv     = 1'b0;
        ref_take  = 1'b0;
        cnt_done  = (q.cnt == '0);
        req_ready = (q.state == ST_IDLE) && !ref_pending;
        if (!cnt_done) n.cnt = q.cnt - 1'b1;
        case (q.state)
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_take = 1'b1;
                    n.state  = ST_REF;
                    n.cnt    = REF_END;
                    n.row    = ref_row;
                end else if (req_valid) begin
                    n.state = ST_ACT;
                    n.cnt   = ACT_END;
                    n.row   = req_row;
                    n.col   = req_col;
                    n.edo   = edo_mode;
                    n.beat  = '0;
                end
            end
            ST_ACT: begin
                if (cnt_done) begin
                    n.state = ST_RD;
                    n.cnt   = RD_FULL;
                end
            end
            ST_RD: begin
                if (cnt_done) begin
                    n.rdv   = 1'b1;
                    n.rdata = dq;
                    if (q.beat == LAST_BEAT) begin
                        n.state = ST_PRE;
                        n.cnt   = PRE_END;
                    end else begin
                        n.state = ST_CPR;
                        n.cnt   = CPR_END;
                        n.col   = q.col + 1'b1;
                        n.beat  = q.beat + 1'b1;
                    end
                end
            end
            ST_CPR: begin
                if (cnt_done) begin
                    n.state = ST_RD;
                    n.cnt   = q.edo ? RD_SHORT : RD_FULL;
                end
            end
            ST_PRE: begin
                if (cnt_done) n.state = ST_IDLE;
            end
            ST_REF: begin
                if (cnt_done) begin
                    n.state = ST_PRE;
                    n.cnt   = PRE_END;
                end
            end
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        ras_n    = !(q.state == ST_ACT || q.state == ST_RD ||
                     q.state == ST_CPR || q.state == ST_REF);
        cas_n    = (q.state != ST_RD);
        oe_n     = !(q.state == ST_ACT || q.state == ST_RD || q.state == ST_CPR);
        asel     = (q.state == ST_RD || q.state == ST_CPR) ? AS_COL : AS_ROW;
        row_out  = q.row;
        col_out  = q.col;
        rd_valid = q.rdv;
        rd_data  = q.rdata;
    end
endmodule

// File: rtl/pgdram_burst_ctrl.sv
module pgdram_burst_ctrl
    import pgd_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 32,
    parameter int BURST_LEN    = 4,
    parameter int RAS_TO_CAS   = 3,
    parameter int CAS_LOW      = 2,
    parameter int CAS_HIGH     = 1,
    parameter int RAS_PRE      = 3,
    parameter int REF_INTERVAL = 200,
    localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edo_mode,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              oe_n,
    output logic              we_n,
    input  logic [DATA_W-1:0] dram_dq,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic             ref_pending, ref_take;
    logic [ROW_W-1:0] ref_row, row_sel;
    logic [COL_W-1:0] col_sel;
    pgd_asel_e        asel;

    pgd_refresh_timer #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (ROW_W)
    ) ref_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (ref_take),
        .pending (ref_pending),
        .ref_row (ref_row)
    );

    pgd_burst_fsm #(
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .DATA_W     (DATA_W),
        .BURST_LEN  (BURST_LEN),
        .RAS_TO_CAS (RAS_TO_CAS),
        .CAS_LOW    (CAS_LOW),
        .CAS_HIGH   (CAS_HIGH),
        .RAS_PRE    (RAS_PRE)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_row     (req_row),
        .req_col     (req_col),
        .edo_mode    (edo_mode),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .dq          (dram_dq),
        .req_ready   (req_ready),
        .ref_take    (ref_take),
        .asel        (asel),
        .row_out     (row_sel),
        .col_out     (col_sel),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .oe_n        (oe_n),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    pgd_addr_mux #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) mux_i (
        .sel  (asel),
        .row  (row_sel),
        .col  (col_sel),
        .addr (dram_addr)
    );

    assign we_n = 1'b1;
endmodule

// File: rtl/pgd_burst_ctrl_chk.sv
module pgd_burst_ctrl_chk #(
    parameter int RAS_PRE = 3
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic req_ready,
    input logic rd_valid
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                hi_cnt <= 8'hff;
        else if (!ras_n)           hi_cnt <= 8'd0;
        else if (hi_cnt != 8'hff)  hi_cnt <= hi_cnt + 8'd1;
    end

    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n); // R9

    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= 8'(RAS_PRE))); // R7

    AST_NO_ACCEPT_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !req_ready); // R7

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!cas_n)); // R3

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R10
endmodule

bind pgdram_burst_ctrl pgd_burst_ctrl_chk #(.RAS_PRE(RAS_PRE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid)
);

// File: tb/pgdram_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgdram_burst_ctrl_tb_top;
    localparam int R   = 3;
    localparam int C   = 2;
    localparam int H   = 1;
    localparam int P   = 3;
    localparam int IV  = 200;
    localparam int BL  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edo_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_ready;
    logic [9:0]  dram_addr;
    logic        ras_n, cas_n, oe_n, we_n;
    logic [31:0] dram_dq;
    logic        rd_valid;
    logic [31:0] rd_data;

    always #10 clk = ~clk;

    pgdram_burst_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .edo_mode(edo_mode), .req_valid(req_valid),
        .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
        .we_n(we_n), .dram_dq(dram_dq), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // behavioural DRAM: row latched when the row strobe falls
    logic [9:0] row_lat = '0;
    assign dram_dq = !cas_n ? {6'h2a, row_lat, 8'h5c, dram_addr[7:0]} : 32'h0;

    int nchk = 0, nfail = 0;
    int cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference model state
    int         qt[$];
    logic [31:0] qd[$];
    int  acc_cyc = -100;
    logic [9:0] exp_row = '0;
    int  low_exp = 0;
    int  fall_cyc = 0, rise_cyc = -1000;
    bit  prev_ras = 1'b1;
    bit  in_ref = 0, ref_cas = 0;
    logic [9:0] ref_exp = '0;
    bit  quiet = 0;
    int  nq = 0, last_ref = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ras_n && prev_ras) begin
                chk((cyc - rise_cyc) >= P, "R7 precharge", cyc - rise_cyc, P);
                chk(we_n === 1'b1, "R9 we_n", we_n, 1);
                if (cyc == acc_cyc) begin
                    chk(dram_addr == exp_row, "R2 row on fall", dram_addr, exp_row);
                    in_ref = 0;
                end else begin
                    chk(dram_addr == ref_exp, "R8 refresh row", dram_addr, ref_exp);
                    ref_exp = ref_exp + 1'b1;
                    low_exp = R + C;
                    in_ref = 1;
                    ref_cas = 0;
                    if (quiet) begin
                        nq++;
                        if (nq >= 3) chk((cyc - last_ref) == IV, "R8 period", cyc - last_ref, IV);
                        last_ref = cyc;
                    end
                end
                row_lat = dram_addr;
                fall_cyc = cyc;
            end
            if (!ras_n) begin
                chk(req_ready == 1'b0, "R7 ready while open", req_ready, 0);
                if (in_ref && !cas_n) ref_cas = 1;
            end
            if (ras_n && !prev_ras) begin
                chk((cyc - fall_cyc) == low_exp, in_ref ? "R8 refresh length" : "R4/R5 row open length",
                    cyc - fall_cyc, low_exp);
                if (in_ref) chk(ref_cas == 0, "R8 no column strobe", ref_cas, 0);
                rise_cyc = cyc;
            end
            prev_ras = ras_n;
            if (qt.size() > 0 && qt[0] == cyc) begin
                chk(rd_valid == 1'b1, "R4/R5 beat timing", rd_valid, 1);
                chk(rd_data == qd[0], "R3 word value", rd_data, qd[0]);
                void'(qt.pop_front());
                void'(qd.pop_front());
            end else if (rd_valid) begin
                chk(0, "R10 unexpected valid", rd_valid, 0);
            end
        end
    end

    task automatic burst(input logic [9:0] row, input logic [7:0] col, input bit mode, input bit flip);
        int gap;
        int a;
        @(negedge clk);
        req_valid = 1'b1; req_row = row; req_col = col; edo_mode = mode;
        while (!req_ready) @(negedge clk);
        a = cyc + 1;
        gap = mode ? (H + C - 1) : (H + C);
        for (int i = 0; i < BL; i++) begin
            logic [7:0] c;
            c = col + 8'(i);
            qt.push_back(a + R + C + i * gap);
            qd.push_back({6'h2a, row, 8'h5c, c});
        end
        exp_row = row;
        low_exp = R + C + (BL - 1) * gap;
        acc_cyc = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) edo_mode = !mode;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk({ras_n, cas_n, oe_n, we_n} == 4'hf, "R1 strobes in reset", {ras_n, cas_n, oe_n, we_n}, 4'hf);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ras_n, cas_n, oe_n, we_n} == 4'hf, "R1 strobes idle", {ras_n, cas_n, oe_n, we_n}, 4'hf);
        chk(rd_valid == 1'b0, "R1 valid low", rd_valid, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

        burst(10'h005, 8'h00, 1'b0, 1'b0);          // R4 plain 5-3-3-3
        burst(10'h3ff, 8'hfe, 1'b1, 1'b0);          // R5 EDO, R3 column wrap
        burst(10'h123, 8'h40, 1'b0, 1'b1);          // R6 mode flips to 1 mid-burst
        burst(10'h0a5, 8'h7f, 1'b1, 1'b1);          // R6 mode flips to 0 mid-burst
        for (int k = 0; k < 28; k++) begin
            burst(10'((k * 37 + 11) % 1024), 8'((k * 29 + 3) % 256), k[0], k[1]);
        end
        while (qt.size() > 0) @(negedge clk);
        repeat (20) @(negedge clk);
        quiet = 1;                                   // R8 idle refresh period
        repeat (900) @(negedge clk);
        chk(nq >= 3, "R8 refreshes in idle window", nq, 3);
        chk(qt.size() == 0, "R10 all beats delivered", qt.size(), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule